// File: doc/BRIEF.md
# Ramped Stereo Digital Attenuator

This block sets the volume of a stereo stream of 16-bit two's-complement samples. The left and right channels each keep their own target attenuation, given in whole decibels from 0 dB down to 64 dB. A control request sets a channel's target. The attenuation actually applied moves toward that target by one decibel for each incoming sample, so a volume change is heard as a short ramp and never as a step. A single master mute silences both outputs. While the mute is on, the ramp keeps running, so turning the mute off resumes at whatever level the ramp has reached by then.

Requests that the block does not support are refused with a one-cycle stall pulse and have no effect. These are volume requests to the master channel, mute requests to a single channel, and any request to the reserved channel code. The unscaled samples leave the block on a separate pass-through port with the same timing as the scaled ones, for digital outputs that must not be affected by the volume setting.

Top module: `stereo_vol_ramp`

## Requirements
- R1: While reset is asserted and after it is released:
  - both current attenuation levels read 0;
  - `out_valid_o`, `req_stall_o` and the sample outputs are 0;
  - mute is off and both targets are 0 dB.
- R2: One cycle after a cycle with `smp_valid_i`=1, the output is `clamp(floor((s*G[n] + 16384) / 32768))` for each channel, held until the next sample.
  - `s` is the input sample and `n` is that channel's level just before the sampling edge.
  - `G[n] = round(32768 * 10^(-n/20))`, so 0 dB gives `G[0] = 32768` and passes samples through unchanged.
  - The clamp range is -32768 to 32767.
- R3: At each sampling edge, a channel's current level moves by exactly 1 toward its target and stops once it is equal to the target. The level does not change in a cycle without a sample.
- R4: The two channels hold independent targets and levels. A write to one channel never changes the other.
- R5: An accepted volume write with a value above 64 sets the target to 64. A level is never above 64.
- R6: A new target takes effect from the next sample, even in the middle of a ramp. The ramp reverses direction if the new target lies on the other side of the current level.
- R7: A volume request (`req_mute_i`=0) to channel code 0 (master) causes `req_stall_o`=1 in the next cycle and changes nothing.
- R8: Any of the following causes `req_stall_o`=1 in the next cycle and changes nothing:
  - a mute request (`req_mute_i`=1) to channel code 1 (left) or 2 (right);
  - any request to channel code 3.
- R9: A mute request to channel code 0 sets the mute state to `req_data_i[0]`, where 1 means muted.
  - While muted, every scaled output is 0.
  - The levels keep ramping while muted, and after unmute the output scales with the level that has been reached.
- R10: One cycle after each sample, the pass-through outputs carry the unscaled input samples. `out_valid_o` is 1 in exactly the cycles that follow a cycle with `smp_valid_i`=1.
- R11: Accepted requests do not stall. These are volume writes to channel codes 1 and 2, and mute requests to channel code 0. Without a request, `req_stall_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid_i | input | 1 | Sample strobe, one cycle per stereo sample |
| smp_l_i | input | 16 | Left input sample, two's complement |
| smp_r_i | input | 16 | Right input sample, two's complement |
| req_valid_i | input | 1 | Control request strobe |
| req_mute_i | input | 1 | 1 = mute request, 0 = volume request |
| req_chan_i | input | 2 | Channel code: 0 master, 1 left, 2 right, 3 reserved |
| req_data_i | input | 7 | Attenuation in dB for volume requests; bit 0 is the mute state for mute requests |
| req_stall_o | output | 1 | One-cycle pulse after a rejected request |
| out_valid_o | output | 1 | Scaled and pass-through outputs are new this cycle |
| out_l_o | output | 16 | Scaled left sample |
| out_r_o | output | 16 | Scaled right sample |
| thru_l_o | output | 16 | Unscaled left sample |
| thru_r_o | output | 16 | Unscaled right sample |
| att_l_o | output | 7 | Current left attenuation level in dB |
| att_r_o | output | 7 | Current right attenuation level in dB |

## Verification
A wrong level register shows on `att_l_o`/`att_r_o` right after the sampling edge. It also shows in the scaled samples one cycle after that edge, as a value that does not fit the gain table.

A target register that is wrong or was never written shows up only through the ramp. The bench therefore follows each write with enough samples to reach, cross or reverse the target, and checks the level after every sample.

A wrong mute state or wrong request decoding shows as zeros where a scaled value is expected, or the other way round. It also shows in the stall pulse one cycle after the request. The bench checks the outputs in the first sample after every request.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int SMP_W   = 16;
  localparam int ATT_W   = 7;
  localparam int MAX_ATT = 64;
  localparam int FRAC_W  = 15;
  localparam int COEF_W  = FRAC_W + 2;

  typedef enum logic [1:0] {
    CH_MASTER = 2'd0,
    CH_LEFT   = 2'd1,
    CH_RIGHT  = 2'd2,
    CH_RSVD   = 2'd3
  } chan_e;

  // Rounded fixed-point value of 10^(-n/20) with FRAC_W fraction bits
  function automatic logic [COEF_W-1:0] db_coef(input int n);
    real g;
    g = (2.0 ** FRAC_W) * (10.0 ** (-n / 20.0));
    return COEF_W'($rtoi(g + 0.5));
  endfunction
endpackage

// File: rtl/atten_gain_rom.sv
module atten_gain_rom #(
  parameter int ATT_W   = atten_pkg::ATT_W,
  parameter int MAX_ATT = atten_pkg::MAX_ATT,
  parameter int COEF_W  = atten_pkg::COEF_W
) (
  input  logic [ATT_W-1:0]  idx_i,
  output logic [COEF_W-1:0] coef_o
);
  localparam int ENTRIES = MAX_ATT + 1;

  logic [COEF_W-1:0] tab [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_tab
    localparam logic [COEF_W-1:0] C = atten_pkg::db_coef(i);
    assign tab[i] = C;
  end

  always_comb begin
    if (int'(idx_i) > MAX_ATT) coef_o = tab[MAX_ATT];
    else                       coef_o = tab[idx_i];
  end
endmodule

// File: rtl/atten_scale.sv
module atten_scale #(
  parameter int SMP_W  = atten_pkg::SMP_W,
  parameter int COEF_W = atten_pkg::COEF_W,
  parameter int FRAC_W = atten_pkg::FRAC_W
) (
  input  logic [SMP_W-1:0]  smp_i,
  input  logic [COEF_W-1:0] coef_i,
  output logic [SMP_W-1:0]  res_o
);
  localparam int PROD_W = SMP_W + COEF_W + 1;
  localparam logic signed [PROD_W-1:0] SMAX = PROD_W'((64'sd1 <<< (SMP_W-1)) - 1);
  localparam logic signed [PROD_W-1:0] SMIN = -SMAX - 1;
  localparam logic signed [PROD_W-1:0] HALF = PROD_W'(64'sd1 <<< (FRAC_W-1));

  logic signed [PROD_W-1:0] s_ext, c_ext, prod, rnd, shf;

  always_comb begin
    s_ext = $signed({{(COEF_W+1){smp_i[SMP_W-1]}}, smp_i});
    c_ext = $signed({{(SMP_W+1){1'b0}}, coef_i});
    prod  = s_ext * c_ext;
    rnd   = prod + HALF;
    shf   = rnd >>> FRAC_W;
    if (shf > SMAX)      res_o = SMAX[SMP_W-1:0];
    else if (shf < SMIN) res_o = SMIN[SMP_W-1:0];
    else                 res_o = shf[SMP_W-1:0];
  end
endmodule

// File: rtl/atten_ramp.sv
module atten_ramp #(
  parameter int ATT_W = atten_pkg::ATT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en_i,
  input  logic             wr_en_i,
  input  logic [ATT_W-1:0] wr_val_i,
  output logic [ATT_W-1:0] cur_o
);
  logic [ATT_W-1:0] tgt_q, tgt_d, cur_q, cur_d;

  always_comb begin
    tgt_d = wr_en_i ? wr_val_i : tgt_q;
    cur_d = cur_q;
    if (step_en_i) begin
      if (cur_q < tgt_q)      cur_d = cur_q + ATT_W'(1);
      else if (cur_q > tgt_q) cur_d = cur_q - ATT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '0;
      cur_q <= '0;
    end else begin
      tgt_q <= tgt_d;
      cur_q <= cur_d;
    end
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/atten_req_decode.sv
module atten_req_decode #(
  parameter int ATT_W   = atten_pkg::ATT_W,
  parameter int MAX_ATT = atten_pkg::MAX_ATT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid_i,
  input  logic             req_mute_i,
  input  logic [1:0]       req_chan_i,
  input  logic [ATT_W-1:0] req_data_i,
  output logic [1:0]       wr_en_o,
  output logic [ATT_W-1:0] wr_val_o,
  output logic             mute_o,
  output logic             stall_o
);
  import atten_pkg::*;

  logic acc_vol, acc_mute, stall_d, mute_d, mute_q, stall_q;

  always_comb begin
    acc_vol  = req_valid_i && !req_mute_i &&
               (req_chan_i == CH_LEFT || req_chan_i == CH_RIGHT);
    acc_mute = req_valid_i && req_mute_i && (req_chan_i == CH_MASTER);
    stall_d  = req_valid_i && !(acc_vol || acc_mute);
    mute_d   = acc_mute ? req_data_i[0] : mute_q;
    wr_en_o  = {acc_vol && (req_chan_i == CH_RIGHT),
                acc_vol && (req_chan_i == CH_LEFT)};
    wr_val_o = (int'(req_data_i) > MAX_ATT) ? ATT_W'(MAX_ATT) : req_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mute_q  <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      mute_q  <= mute_d;
      stall_q <= stall_d;
    end
  end

  assign mute_o  = mute_q;
  assign stall_o = stall_q;
endmodule

// File: rtl/stereo_vol_ramp.sv
module stereo_vol_ramp #(
  parameter int SMP_W   = atten_pkg::SMP_W,
  parameter int ATT_W   = atten_pkg::ATT_W,
  parameter int MAX_ATT = atten_pkg::MAX_ATT,
  parameter int FRAC_W  = atten_pkg::FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_l_i,
  input  logic [SMP_W-1:0] smp_r_i,
  input  logic             req_valid_i,
  input  logic             req_mute_i,
  input  logic [1:0]       req_chan_i,
  input  logic [ATT_W-1:0] req_data_i,
  output logic             req_stall_o,
  output logic             out_valid_o,
  output logic [SMP_W-1:0] out_l_o,
  output logic [SMP_W-1:0] out_r_o,
  output logic [SMP_W-1:0] thru_l_o,
  output logic [SMP_W-1:0] thru_r_o,
  output logic [ATT_W-1:0] att_l_o,
  output logic [ATT_W-1:0] att_r_o
);
  localparam int NCH    = 2;
  localparam int COEF_W = FRAC_W + 2;

  logic [1:0]       wr_en;
  logic [ATT_W-1:0] wr_val;
  logic             mute;

  logic [SMP_W-1:0]  smp_in  [NCH];
  logic [ATT_W-1:0]  cur     [NCH];
  logic [COEF_W-1:0] coef    [NCH];
  logic [SMP_W-1:0]  scaled  [NCH];
  logic [SMP_W-1:0]  out_d   [NCH];
  logic [SMP_W-1:0]  out_q   [NCH];
  logic [SMP_W-1:0]  thru_q  [NCH];
  logic              vld_q;

  assign smp_in[0] = smp_l_i;
  assign smp_in[1] = smp_r_i;

  atten_req_decode #(.ATT_W(ATT_W), .MAX_ATT(MAX_ATT)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid_i), .req_mute_i(req_mute_i),
    .req_chan_i(req_chan_i), .req_data_i(req_data_i),
    .wr_en_o(wr_en), .wr_val_o(wr_val), .mute_o(mute), .stall_o(req_stall_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    atten_ramp #(.ATT_W(ATT_W)) u_ramp (
      .clk(clk), .rst_n(rst_n), .step_en_i(smp_valid_i),
      .wr_en_i(wr_en[c]), .wr_val_i(wr_val), .cur_o(cur[c])
    );

    atten_gain_rom #(.ATT_W(ATT_W), .MAX_ATT(MAX_ATT), .COEF_W(COEF_W)) u_rom (
      .idx_i(cur[c]), .coef_o(coef[c])
    );

    atten_scale #(.SMP_W(SMP_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_scale (
      .smp_i(smp_in[c]), .coef_i(coef[c]), .res_o(scaled[c])
    );

    always_comb out_d[c] = mute ? '0 : scaled[c];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_q[c]  <= '0;
        thru_q[c] <= '0;
      end else if (smp_valid_i) begin
        out_q[c]  <= out_d[c];
        thru_q[c] <= smp_in[c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= smp_valid_i;
  end

  assign out_valid_o = vld_q;
  assign out_l_o     = out_q[0];
  assign out_r_o     = out_q[1];
  assign thru_l_o    = thru_q[0];
  assign thru_r_o    = thru_q[1];
  assign att_l_o     = cur[0];
  assign att_r_o     = cur[1];
endmodule

// File: rtl/stereo_vol_ramp_chk.sv
module stereo_vol_ramp_chk #(
  parameter int SMP_W   = atten_pkg::SMP_W,
  parameter int ATT_W   = atten_pkg::ATT_W,
  parameter int MAX_ATT = atten_pkg::MAX_ATT
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid_i,
  input logic [SMP_W-1:0] smp_l_i,
  input logic [SMP_W-1:0] smp_r_i,
  input logic             req_valid_i,
  input logic             req_mute_i,
  input logic [1:0]       req_chan_i,
  input logic             req_stall_o,
  input logic             out_valid_o,
  input logic [SMP_W-1:0] out_l_o,
  input logic [SMP_W-1:0] out_r_o,
  input logic [SMP_W-1:0] thru_l_o,
  input logic [SMP_W-1:0] thru_r_o,
  input logic [ATT_W-1:0] att_l_o,
  input logic [ATT_W-1:0] att_r_o
);
  assert_step_l_R3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_i |=> (int'(att_l_o) - int'($past(att_l_o)) <= 1) &&
                    (int'($past(att_l_o)) - int'(att_l_o) <= 1));
  assert_step_r_R3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_i |=> (int'(att_r_o) - int'($past(att_r_o)) <= 1) &&
                    (int'($past(att_r_o)) - int'(att_r_o) <= 1));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid_i |=> $stable(att_l_o) && $stable(att_r_o));
  assert_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(att_l_o) <= MAX_ATT && int'(att_r_o) <= MAX_ATT);
  assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid_i |=> $stable(out_l_o) && $stable(out_r_o));
  assert_master_vol_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i && !req_mute_i && req_chan_i == 2'd0 |=> req_stall_o);
  assert_chan_mute_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i && req_mute_i && req_chan_i != 2'd0 |=> req_stall_o);
  assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i && !req_mute_i && (req_chan_i == 2'd1 || req_chan_i == 2'd2)
    |=> !req_stall_o);
  assert_no_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> !req_stall_o);
  assert_thru_R10: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_i |=> out_valid_o && thru_l_o == $past(smp_l_i) &&
                    thru_r_o == $past(smp_r_i));
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid_i |=> !out_valid_o);
endmodule

bind stereo_vol_ramp stereo_vol_ramp_chk #(
  .SMP_W(SMP_W), .ATT_W(ATT_W), .MAX_ATT(MAX_ATT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid_i(smp_valid_i),
  .smp_l_i(smp_l_i), .smp_r_i(smp_r_i),
  .req_valid_i(req_valid_i), .req_mute_i(req_mute_i), .req_chan_i(req_chan_i),
  .req_stall_o(req_stall_o), .out_valid_o(out_valid_o),
  .out_l_o(out_l_o), .out_r_o(out_r_o),
  .thru_l_o(thru_l_o), .thru_r_o(thru_r_o),
  .att_l_o(att_l_o), .att_r_o(att_r_o)
);

// File: tb/stereo_vol_ramp_tb.sv
module stereo_vol_ramp_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_valid_i;
  logic [15:0] smp_l_i, smp_r_i;
  logic        req_valid_i, req_mute_i;
  logic [1:0]  req_chan_i;
  logic [6:0]  req_data_i;
  logic        req_stall_o, out_valid_o;
  logic [15:0] out_l_o, out_r_o, thru_l_o, thru_r_o;
  logic [6:0]  att_l_o, att_r_o;

  int checks = 0;
  int fails  = 0;
  int m_cur [2];
  int m_tgt [2];
  bit m_mute;

  always #2 clk = ~clk;

  stereo_vol_ramp u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid_i(smp_valid_i),
    .smp_l_i(smp_l_i), .smp_r_i(smp_r_i),
    .req_valid_i(req_valid_i), .req_mute_i(req_mute_i),
    .req_chan_i(req_chan_i), .req_data_i(req_data_i),
    .req_stall_o(req_stall_o), .out_valid_o(out_valid_o),
    .out_l_o(out_l_o), .out_r_o(out_r_o),
    .thru_l_o(thru_l_o), .thru_r_o(thru_r_o),
    .att_l_o(att_l_o), .att_r_o(att_r_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int gain(input int n);
    real g;
    g = 32768.0 * (10.0 ** (-n / 20.0));
    return int'(g);
  endfunction

  function automatic int exp_out(input int s, input int n, input bit mute);
    longint p, r;
    if (mute) return 0;
    p = longint'(s) * longint'(gain(n));
    r = (p + 64'sd16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic send_sample(input int l, input int r, input string tag);
    int el, er;
    @(negedge clk);
    smp_valid_i = 1'b1;
    smp_l_i = 16'(l);
    smp_r_i = 16'(r);
    el = exp_out(l, m_cur[0], m_mute);
    er = exp_out(r, m_cur[1], m_mute);
    for (int c = 0; c < 2; c++) begin
      if (m_cur[c] < m_tgt[c]) m_cur[c]++;
      else if (m_cur[c] > m_tgt[c]) m_cur[c]--;
    end
    @(negedge clk);
    smp_valid_i = 1'b0;
    chk({tag, " out_l R2"}, int'($signed(out_l_o)), el);
    chk({tag, " out_r R2"}, int'($signed(out_r_o)), er);
    chk({tag, " thru_l R10"}, int'($signed(thru_l_o)), l);
    chk({tag, " thru_r R10"}, int'($signed(thru_r_o)), r);
    chk({tag, " valid R10"}, int'(out_valid_o), 1);
    chk({tag, " att_l R3"}, int'(att_l_o), m_cur[0]);
    chk({tag, " att_r R3"}, int'(att_r_o), m_cur[1]);
  endtask

  task automatic send_req(input bit mute, input int ch, input int data, input string tag);
    bit ok;
    @(negedge clk);
    req_valid_i = 1'b1;
    req_mute_i  = mute;
    req_chan_i  = 2'(ch);
    req_data_i  = 7'(data);
    ok = (!mute && (ch == 1 || ch == 2)) || (mute && ch == 0);
    if (ok && !mute) m_tgt[ch-1] = (data > 64) ? 64 : data;
    if (ok && mute) m_mute = data[0];
    @(negedge clk);
    req_valid_i = 1'b0;
    chk({tag, " stall R7 R8 R11"}, int'(req_stall_o), ok ? 0 : 1);
    chk({tag, " valid idle R10"}, int'(out_valid_o), 0);
  endtask

  function automatic int rnd_smp();
    return int'($signed(16'($urandom)));
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    smp_valid_i = 1'b0; smp_l_i = '0; smp_r_i = '0;
    req_valid_i = 1'b0; req_mute_i = 1'b0; req_chan_i = '0; req_data_i = '0;
    m_cur = '{0, 0}; m_tgt = '{0, 0}; m_mute = 1'b0;
    repeat (3) @(negedge clk);
    chk("reset att_l R1", int'(att_l_o), 0);
    chk("reset valid R1", int'(out_valid_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("post-reset att_r R1", int'(att_r_o), 0);
    chk("post-reset stall R1", int'(req_stall_o), 0);
    chk("post-reset out_l R1", int'(out_l_o), 0);

    // R2: unity gain at 0 dB, full-scale extremes
    send_sample(32767, -32768, "unity R2");
    send_sample(-1, 1, "unity small R2");

    // R3 R4: ramp left only
    send_req(1'b0, 1, 3, "left tgt3 R4");
    for (int i = 0; i < 5; i++) send_sample(30000, -30000, "ramp R3 R4");
    chk("left settled R3", int'(att_l_o), 3);
    chk("right untouched R4", int'(att_r_o), 0);

    // R5: clamp above 64
    send_req(1'b0, 2, 100, "right clamp R5");
    for (int i = 0; i < 70; i++) send_sample(rnd_smp(), 32767, "clamp ramp R5");
    chk("right at floor R5", int'(att_r_o), 64);

    // R6: retarget mid-ramp with reversal
    send_req(1'b0, 1, 20, "left tgt20 R6");
    for (int i = 0; i < 5; i++) send_sample(rnd_smp(), rnd_smp(), "down R6");
    send_req(1'b0, 1, 0, "left tgt0 R6");
    send_sample(12345, -12345, "reverse R6");
    chk("reversed level R6", int'(att_l_o), 7);

    // R7: master volume rejected
    send_req(1'b0, 0, 30, "master vol R7");
    send_sample(20000, 20000, "after master vol R7");

    // R8: per-channel mute and reserved channel rejected
    send_req(1'b1, 1, 1, "left mute R8");
    send_sample(20000, 20000, "after left mute R8");
    send_req(1'b1, 2, 1, "right mute R8");
    send_req(1'b0, 3, 10, "reserved chan R8");
    send_sample(-20000, 20000, "after rejects R8");

    // R9: master mute, ramp tracks while muted, resume
    send_req(1'b0, 2, 40, "right tgt40 R9");
    send_req(1'b1, 0, 1, "mute on R9");
    for (int i = 0; i < 4; i++) send_sample(25000, 25000, "muted R9");
    chk("ramp while muted R9", int'(att_r_o), 60);
    send_req(1'b1, 0, 0, "mute off R9");
    send_sample(25000, 25000, "unmuted R9");

    // random mix
    for (int i = 0; i < 600; i++) begin
      if (($urandom % 10) < 7) send_sample(rnd_smp(), rnd_smp(), "random");
      else send_req(1'($urandom), int'($urandom % 4), int'($urandom % 128), "random req");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule